// File: doc/BRIEF.md
# Self-Correcting Triplicated Register

This block is a register bank of `WIDTH` bits. Each bit is stored in three flip-flops. A bitwise two-of-three majority voter reads the three copies, and the voted word is the only value the block presents. A single corrupted copy of any bit therefore never reaches the output. The logic that feeds the register is single and unprotected, and it lies outside this block.

The voted word also serves as the repair source. On every clock edge that does not load new data, each copy reloads the voted value instead of keeping its own contents. A disagreeing copy is therefore overwritten one cycle after it goes wrong. Because of this, a later upset in a different copy of the same bit meets two good copies, and the mask holds.

For test, three flip vectors, one for each copy, invert chosen bits of that copy on a single edge. A mismatch vector shows, bit by bit, where the three copies disagree.

Top module: `tmr_scrub_reg`

## Requirements
- R1: On a clock edge where `rst` is high, all three copies become zero. After that edge `dataOut` is 0 and `mismatch` is 0.
- R2: On an edge where `rst` is low, `en` is high and no flip bit is set, all copies load `dataIn`. After that edge `dataOut` equals that `dataIn` and `mismatch` is 0.
- R3: On an edge where `en` is low and no flip bit is set, `dataOut` keeps its previous value whatever `dataIn` is.
- R4: Setting bits in just one of `flipA`, `flipB` or `flipC` on an edge inverts those bits of that copy only. `dataOut` after the edge is the same as it would have been without the flip.
- R5: After an edge where bits are flipped in exactly one copy, `mismatch` equals that copy's flip vector.
- R6: After any edge with `rst` high or with no flip bit set, `mismatch` is 0. Every disagreeing copy has taken the voted value.
- R7: Upsets on the same bit in different copies on consecutive edges are each repaired before the next one arrives, so `dataOut` never changes.
- R8: Flipping the same bit in two copies on one edge inverts that bit of `dataOut`. On the next edge without flips, the third copy takes the inverted value and `mismatch` clears.
- R9: A flip applied together with `en` high inverts the loaded `dataIn` bit in that copy. `dataOut` still shows `dataIn`.
- R10: Reset takes precedence over both `en` and the flip vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Load `dataIn` into all copies |
| dataIn | input | WIDTH | New data word |
| flipA | input | WIDTH | Invert bits of copy A on this edge |
| flipB | input | WIDTH | Invert bits of copy B on this edge |
| flipC | input | WIDTH | Invert bits of copy C on this edge |
| dataOut | output | WIDTH | Majority-voted word |
| mismatch | output | WIDTH | Bits where the copies disagree |

## Verification
The directed patterns separate four cases: a lone upset, which must be masked and then repaired; upsets on one bit that hit alternating copies on consecutive edges, which show whether write-back happens every cycle or only on a load; a double upset on a single edge, which must defeat the vote in a defined way; and flips that coincide with a load or a reset. A seeded random phase then mixes enable, data and flips of one copy per bit with occasional double flips and resets. A bench model of the three copies tells masking apart from repair, because the two differ only in how `mismatch` and later votes evolve.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic clearAll;
    logic loadNew;
  } ctrl_strobes_t;

  localparam int unsigned NUM_COPIES = 3;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic          rst,
  input  logic          en,
  output ctrl_strobes_t strobes
);
  // R10: reset dominates the load strobe
  always_comb begin
    strobes.clearAll = rst;
    strobes.loadNew  = en & ~rst;
  end
endmodule

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] copyA,
  input  logic [WIDTH-1:0] copyB,
  input  logic [WIDTH-1:0] copyC,
  output logic [WIDTH-1:0] voted,
  output logic [WIDTH-1:0] differ
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_comb begin
      voted[b]  = (copyA[b] & copyB[b]) | (copyA[b] & copyC[b]) | (copyB[b] & copyC[b]);
      differ[b] = (copyA[b] ^ copyB[b]) | (copyA[b] ^ copyC[b]);
    end
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  ctrl_strobes_t                    strobes,
  input  logic [WIDTH-1:0]                 dataIn,
  input  logic [NUM_COPIES-1:0][WIDTH-1:0] flipVec,
  output logic [WIDTH-1:0]                 voted,
  output logic [WIDTH-1:0]                 differ
);
  logic [NUM_COPIES-1:0][WIDTH-1:0] copyQ;
  logic [WIDTH-1:0]                 nextSrc;

  assign nextSrc = strobes.loadNew ? dataIn : voted;

  for (genvar k = 0; k < NUM_COPIES; k++) begin : g_copy
    always_ff @(posedge clk) begin
      if (strobes.clearAll) copyQ[k] <= '0;
      else                  copyQ[k] <= nextSrc ^ flipVec[k];
    end
  end

  tmr_voter #(.WIDTH(WIDTH)) u_voter (
    .copyA (copyQ[0]),
    .copyB (copyQ[1]),
    .copyC (copyQ[2]),
    .voted (voted),
    .differ(differ)
  );

  logic pastValid;
  always_ff @(posedge clk) pastValid <= 1'b1;

  // R1: reset clears the word and the disagreement flags
  always_ff @(posedge clk) begin
    if (pastValid && $past(rst))
      a_r1_reset_clears: assert (voted == '0 && differ == '0);
  end

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    (strobes.loadNew && flipVec == '0) |=> (voted == $past(dataIn) && differ == '0));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!strobes.loadNew && flipVec == '0) |=> $stable(voted));

  a_r4_single_masked: assert property (@(posedge clk) disable iff (rst)
    (!strobes.loadNew && flipVec[1] == '0 && flipVec[2] == '0) |=> $stable(voted));

  a_r5_flags_single: assert property (@(posedge clk) disable iff (rst)
    (flipVec[1] == '0 && flipVec[2] == '0) |=> (differ == $past(flipVec[0])));

  a_r6_scrubbed: assert property (@(posedge clk) disable iff (rst)
    (flipVec == '0) |=> (differ == '0));
endmodule

// File: rtl/tmr_scrub_reg.sv
module tmr_scrub_reg
  import tmr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] dataIn,
  input  logic [WIDTH-1:0] flipA,
  input  logic [WIDTH-1:0] flipB,
  input  logic [WIDTH-1:0] flipC,
  output logic [WIDTH-1:0] dataOut,
  output logic [WIDTH-1:0] mismatch
);
  ctrl_strobes_t                    strobes;
  logic [NUM_COPIES-1:0][WIDTH-1:0] flipVec;

  assign flipVec = {flipC, flipB, flipA};

  tmr_ctrl u_ctrl (
    .rst    (rst),
    .en     (en),
    .strobes(strobes)
  );

  tmr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .dataIn (dataIn),
    .flipVec(flipVec),
    .voted  (dataOut),
    .differ (mismatch)
  );
endmodule

// File: tb/tb_tmr_scrub_reg.sv
module tb_tmr_scrub_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst, en;
  logic [W-1:0] dataIn, flipA, flipB, flipC, dataOut, mismatch;

  always #2 clk = ~clk;

  tmr_scrub_reg #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .en(en), .dataIn(dataIn),
    .flipA(flipA), .flipB(flipB), .flipC(flipC),
    .dataOut(dataOut), .mismatch(mismatch)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [W-1:0] mA = '0, mB = '0, mC = '0;

  function automatic logic [W-1:0] maj(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic [W-1:0] dis(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    return (a ^ b) | (a ^ c);
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model, sample after the edge
  task automatic step(bit r, bit e, logic [W-1:0] d, logic [W-1:0] fa,
                      logic [W-1:0] fb, logic [W-1:0] fc);
    logic [W-1:0] src;
    @(negedge clk);
    rst = r; en = e; dataIn = d; flipA = fa; flipB = fb; flipC = fc;
    @(posedge clk);
    if (r) begin
      mA = '0; mB = '0; mC = '0;
    end else begin
      src = e ? d : maj(mA, mB, mC);
      mA = src ^ fa; mB = src ^ fb; mC = src ^ fc;
    end
    #1;
  endtask

  task automatic verify(string tag);
    check({tag, " dataOut"}, dataOut, maj(mA, mB, mC));
    check({tag, " mismatch"}, mismatch, dis(mA, mB, mC));
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] hold;
    void'($urandom(32'd4242));
    rst = 1'b1; en = 1'b0; dataIn = '0; flipA = '0; flipB = '0; flipC = '0;
    // R10 / R1: reset with load and flips active
    step(1, 1, 8'hFF, 8'hFF, 8'h0F, 8'hF0);
    check("R10 dataOut", dataOut, 8'h00);
    check("R1 mismatch", mismatch, 8'h00);
    // R2 load
    step(0, 1, 8'hA5, 0, 0, 0);
    check("R2 dataOut", dataOut, 8'hA5);
    check("R2 mismatch", mismatch, 8'h00);
    // R3 hold with changing input
    step(0, 0, 8'hFF, 0, 0, 0);
    check("R3 dataOut", dataOut, 8'hA5);
    // R4/R5 single upset
    step(0, 0, 8'h00, 8'h01, 0, 0);
    check("R4 dataOut", dataOut, 8'hA5);
    check("R5 mismatch", mismatch, 8'h01);
    // R6 repair
    step(0, 0, 8'h00, 0, 0, 0);
    check("R6 mismatch", mismatch, 8'h00);
    check("R6 dataOut", dataOut, 8'hA5);
    // R7 consecutive upsets on one bit in different copies
    step(0, 0, 8'h00, 0, 8'h80, 0);
    check("R7 dataOut first", dataOut, 8'hA5);
    check("R7 mismatch first", mismatch, 8'h80);
    step(0, 0, 8'h00, 0, 0, 8'h80);
    check("R7 dataOut second", dataOut, 8'hA5);
    check("R7 mismatch second", mismatch, 8'h80);
    step(0, 0, 8'h00, 8'h80, 0, 0);
    check("R7 dataOut third", dataOut, 8'hA5);
    step(0, 0, 8'h00, 0, 0, 0);
    check("R7 mismatch clear", mismatch, 8'h00);
    // R8 double upset breaks the vote, then settles
    step(0, 0, 8'h00, 8'h02, 8'h02, 0);
    check("R8 dataOut", dataOut, 8'hA7);
    check("R8 mismatch", mismatch, 8'h02);
    step(0, 0, 8'h00, 0, 0, 0);
    check("R8 dataOut settled", dataOut, 8'hA7);
    check("R8 mismatch settled", mismatch, 8'h00);
    // R9 flip during load
    step(0, 1, 8'h3C, 0, 0, 8'hFF);
    check("R9 dataOut", dataOut, 8'h3C);
    check("R9 mismatch", mismatch, 8'hFF);
    step(0, 0, 8'h00, 0, 0, 0);
    check("R9 repaired", mismatch, 8'h00);
    // random phase
    for (int i = 0; i < 2000; i++) begin
      logic [W-1:0] fa, fb, fc, pick, d;
      bit r, e;
      int sel;
      r = ($urandom % 50) == 0;
      e = ($urandom % 3) == 0;
      d = W'($urandom);
      fa = '0; fb = '0; fc = '0;
      if (($urandom % 4) == 0) begin
        pick = W'($urandom) & W'($urandom);
        sel = $urandom % 4;
        case (sel)
          0: fa = pick;
          1: fb = pick;
          2: fc = pick;
          default: begin fa = pick; fb = pick; end
        endcase
      end
      hold = dataOut;
      step(r, e, d, fa, fb, fc);
      if (r) verify("R1 random");
      else if (!e && fa == 0 && fb == 0 && fc == 0) begin
        check("R3 random hold", dataOut, hold);
        verify("R6 random");
      end else if (e) verify("R2 random");
      else verify("R4 random");
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule